// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command interpreter on the device side of a parallel NOR flash. Every bus write arrives as a strobe together with an address and a data word. The block follows the multi-write unlock sequences that the host issues. When a sequence completes, it raises a one-cycle start pulse for one of these operations: chip erase, sector erase, program, identifier mode entry, or temporary protection override. The pulse comes with the address and data of the write that completed the sequence. The block also keeps three mode flags: identifier mode, fast-program mode and erase-paused. The engine that carries out programs and erases is outside this block. The engine reports back through a busy input and an erasing input.

The unlock addresses change with the bus width. In 16-bit mode the first unlock write goes to AAAh and the second to 554h. In 32-bit mode they go to 555h and 2AAh. Only the low 12 address bits are compared against these values. Any write that breaks the expected pattern abandons the sequence and returns the decoder to read state. No pulse is raised in that case.

The write input is a valid-only stream. The decoder accepts one write on every clock with `wr_valid` high and never applies back-pressure, so it has no ready output. A write may follow the previous one directly, or after any number of idle cycles. All outputs are registered: a pulse and any change of a flag appear in the cycle after the clock edge that accepted the final write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock pair is AAh written to the first unlock address, then 55h written to the second. In 16-bit mode (`word_mode`=1) these addresses are AAAh and 554h. In 32-bit mode (`word_mode`=0) they are 555h and 2AAh. Only address bits [11:0] are compared. The third write of a sequence must also go to the first unlock address.
- R2: Chip erase takes six writes: unlock pair, 80h, unlock pair, then 10h to the first unlock address. The sixth write raises `chip_erase_go` for one cycle.
- R3: Sector erase takes the same first five writes, then 30h to any address. That write raises `sector_erase_go`, and `op_addr` carries the address of the sixth write.
- R4: Program takes four writes: unlock pair, A0h, then one write of any address and data. That write raises `program_go`, with `op_addr` and `op_data` carrying its address and data.
- R5: The unlock pair followed by 90h raises `autosel_go` and sets `autosel_mode`. A write of F0h to any address from read state clears `autosel_mode` and raises no pulse.
- R6: The unlock pair followed by 60h, then a fourth write, controls the protection override. A fourth write of 01h raises `unprotect_go` with `unprotect_en`=1. A fourth write of 00h raises it with `unprotect_en`=0. Any other fourth value aborts.
- R7: The unlock pair followed by 20h sets `bypass_mode`. While it is set, A0h followed by one more write raises `program_go` for that write. While it is set, 90h followed by 00h clears `bypass_mode`.
- R8: A write that does not fit the current step of a sequence aborts it. The decoder returns to read state, raises no pulse, and clears `autosel_mode`.
- R9: While `eng_busy` is 1, every write except the pause command aborts. This includes writes in the middle of a sequence.
- R10: B0h written while `eng_erasing` is 1 and no pause is active raises `suspend_go` and sets `erase_suspended`. While paused and not busy, 30h written from read state raises `resume_go` and clears `erase_suspended`.
- R11: While `erase_suspended` is 1, three commands are rejected as aborts: the 80h erase set-up, the 20h fast-program entry, and the A0h fast-program command.
- R12: At most one operation pulse is high in any cycle, and each pulse follows an accepted write in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1 = 16-bit bus addressing, 0 = 32-bit |
| wr_valid | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the command byte is bits [7:0] |
| eng_busy | input | 1 | Embedded engine running |
| eng_erasing | input | 1 | Engine running an erase |
| chip_erase_go | output | 1 | Start chip erase pulse |
| sector_erase_go | output | 1 | Start sector erase pulse |
| program_go | output | 1 | Start program pulse |
| autosel_go | output | 1 | Identifier mode entered pulse |
| unprotect_go | output | 1 | Protection override change pulse |
| unprotect_en | output | 1 | With `unprotect_go`: 1 = enable, 0 = disable |
| suspend_go | output | 1 | Pause erase pulse |
| resume_go | output | 1 | Resume erase pulse |
| op_addr | output | ADDR_W | Address of the write that completed the sequence |
| op_data | output | DATA_W | Data of the write that completed the sequence |
| autosel_mode | output | 1 | Identifier mode flag |
| bypass_mode | output | 1 | Fast-program mode flag |
| erase_suspended | output | 1 | Erase-paused flag |

## Verification
The properties assume that `wr_valid` stays low during reset. They also assume that `eng_erasing` is high only while `eng_busy` is high, and that all inputs are known on every clock edge. The stimulus drives inputs only on falling edges and holds the strobe low during reset. It raises `eng_erasing` only together with `eng_busy`, and it never drops the busy input while a sequence is half written.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  localparam int CMP_W = 12;

  localparam logic [7:0] CMD_UNL_A   = 8'hAA;
  localparam logic [7:0] CMD_UNL_B   = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ASEL    = 8'h90;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_UNPROT  = 8'h60;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
  localparam logic [7:0] CMD_BYP_END = 8'h00;
  localparam logic [7:0] CMD_UP_ON   = 8'h01;
  localparam logic [7:0] CMD_UP_OFF  = 8'h00;

  typedef enum logic [3:0] {
    EV_NONE, EV_CHIP, EV_SECT, EV_PROG, EV_ASEL,
    EV_UP_ON, EV_UP_OFF, EV_SUSP, EV_RES
  } fcd_ev_e;

  localparam int EV_COUNT = 9;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_SET, S_SU1, S_SU2,
    S_PROG, S_BPROG, S_BEXIT, S_TUP
  } fcd_state_e;

  localparam int FLAG_ASEL = 0;
  localparam int FLAG_BYP  = 1;
  localparam int FLAG_SUSP = 2;
  localparam int FLAG_N    = 3;

endpackage

// File: rtl/fcd_unlock_match.sv
module fcd_unlock_match
  import fcd_pkg::*;
(
  input  logic [CMP_W-1:0] addr_lo,
  input  logic             word_mode,
  output logic             hit_first,
  output logic             hit_second
);
  localparam logic [CMP_W-1:0] W_FIRST  = CMP_W'(12'hAAA);
  localparam logic [CMP_W-1:0] W_SECOND = CMP_W'(12'h554);
  localparam logic [CMP_W-1:0] D_FIRST  = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] D_SECOND = CMP_W'(12'h2AA);

  logic [CMP_W-1:0] want_first;
  logic [CMP_W-1:0] want_second;

  always_comb begin
    want_first  = word_mode ? W_FIRST  : D_FIRST;
    want_second = word_mode ? W_SECOND : D_SECOND;
    hit_first   = (addr_lo == want_first);
    hit_second  = (addr_lo == want_second);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [7:0]        cmd,
  input  logic              hit_first,
  input  logic              hit_second,
  input  logic              eng_busy,
  input  logic              eng_erasing,
  input  logic              bypass,
  input  logic              suspended,
  output fcd_ev_e           ev,
  output logic [FLAG_N-1:0] flag_set,
  output logic [FLAG_N-1:0] flag_clr
);
  fcd_state_e st, nxt;
  logic abort;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt      = st;
    ev       = EV_NONE;
    flag_set = '0;
    flag_clr = '0;
    abort    = 1'b0;
    if (wr_valid) begin
      nxt = S_IDLE;
      if (eng_busy) begin
        if (cmd == CMD_SUSPEND && eng_erasing && !suspended) begin
          ev = EV_SUSP;
          flag_set[FLAG_SUSP] = 1'b1;
        end else begin
          abort = 1'b1;
        end
      end else begin
        unique case (st)
          S_IDLE: begin
            if (suspended && cmd == CMD_RESUME) begin
              ev = EV_RES;
              flag_clr[FLAG_SUSP] = 1'b1;
            end else if (hit_first && cmd == CMD_UNL_A)
              nxt = S_U1;
            else if (bypass && !suspended && cmd == CMD_PROG)
              nxt = S_BPROG;
            else if (bypass && cmd == CMD_ASEL)
              nxt = S_BEXIT;
            else
              abort = 1'b1;   // includes the F0h reset command
          end
          S_U1: begin
            if (hit_second && cmd == CMD_UNL_B) nxt = S_U2;
            else abort = 1'b1;
          end
          S_U2: begin
            if (!hit_first) abort = 1'b1;
            else begin
              unique case (cmd)
                CMD_SETUP:  if (!suspended) nxt = S_SET; else abort = 1'b1;
                CMD_PROG:   nxt = S_PROG;
                CMD_ASEL: begin
                  ev = EV_ASEL;
                  flag_set[FLAG_ASEL] = 1'b1;
                end
                CMD_BYPASS: if (!suspended) flag_set[FLAG_BYP] = 1'b1;
                            else abort = 1'b1;
                CMD_UNPROT: nxt = S_TUP;
                default:    abort = 1'b1;
              endcase
            end
          end
          S_SET: begin
            if (hit_first && cmd == CMD_UNL_A) nxt = S_SU1;
            else abort = 1'b1;
          end
          S_SU1: begin
            if (hit_second && cmd == CMD_UNL_B) nxt = S_SU2;
            else abort = 1'b1;
          end
          S_SU2: begin
            if (hit_first && cmd == CMD_CHIP) ev = EV_CHIP;
            else if (cmd == CMD_SECT)         ev = EV_SECT;
            else abort = 1'b1;
          end
          S_PROG, S_BPROG: ev = EV_PROG;
          S_BEXIT: begin
            if (cmd == CMD_BYP_END) flag_clr[FLAG_BYP] = 1'b1;
            else abort = 1'b1;
          end
          S_TUP: begin
            if (cmd == CMD_UP_ON)       ev = EV_UP_ON;
            else if (cmd == CMD_UP_OFF) ev = EV_UP_OFF;
            else abort = 1'b1;
          end
          default: abort = 1'b1;
        endcase
      end
      if (abort) flag_clr[FLAG_ASEL] = 1'b1;
    end
  end
endmodule

// File: rtl/fcd_mode_flags.sv
module fcd_mode_flags
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] flag_set,
  input  logic [FLAG_N-1:0] flag_clr,
  output logic [FLAG_N-1:0] flags
);
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (flag_set[i]) flags[i] <= 1'b1;
      else if (flag_clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fcd_pulse_reg.sv
module fcd_pulse_reg
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
)(
  input  logic                clk,
  input  logic                rst_n,
  input  fcd_ev_e             ev,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  output logic [EV_COUNT-1:1] pulse,
  output logic [ADDR_W-1:0]   op_addr,
  output logic [DATA_W-1:0]   op_data
);
  fcd_ev_e ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_q    <= EV_NONE;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      ev_q <= ev;
      if (ev != EV_NONE) begin
        op_addr <= addr;
        op_data <= data;
      end
    end
  end

  for (genvar i = 1; i < EV_COUNT; i++) begin : g_pulse
    assign pulse[i] = (ev_q == fcd_ev_e'(i));
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_mode,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  input  logic              eng_erasing,
  output logic              chip_erase_go,
  output logic              sector_erase_go,
  output logic              program_go,
  output logic              autosel_go,
  output logic              unprotect_go,
  output logic              unprotect_en,
  output logic              suspend_go,
  output logic              resume_go,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              autosel_mode,
  output logic              bypass_mode,
  output logic              erase_suspended
);
  logic                hit_first, hit_second;
  fcd_ev_e             ev;
  logic [FLAG_N-1:0]   flag_set, flag_clr, flags;
  logic [EV_COUNT-1:1] pulse;

  fcd_unlock_match u_match (
    .addr_lo(wr_addr[CMP_W-1:0]), .word_mode(word_mode),
    .hit_first(hit_first), .hit_second(hit_second)
  );

  fcd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cmd(wr_data[7:0]),
    .hit_first(hit_first), .hit_second(hit_second),
    .eng_busy(eng_busy), .eng_erasing(eng_erasing),
    .bypass(flags[FLAG_BYP]), .suspended(flags[FLAG_SUSP]),
    .ev(ev), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  fcd_mode_flags u_flags (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .flags(flags)
  );

  fcd_pulse_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ev(ev), .addr(wr_addr), .data(wr_data),
    .pulse(pulse), .op_addr(op_addr), .op_data(op_data)
  );

  assign chip_erase_go   = pulse[EV_CHIP];
  assign sector_erase_go = pulse[EV_SECT];
  assign program_go      = pulse[EV_PROG];
  assign autosel_go      = pulse[EV_ASEL];
  assign unprotect_go    = pulse[EV_UP_ON] | pulse[EV_UP_OFF];
  assign unprotect_en    = pulse[EV_UP_ON];
  assign suspend_go      = pulse[EV_SUSP];
  assign resume_go       = pulse[EV_RES];
  assign autosel_mode    = flags[FLAG_ASEL];
  assign bypass_mode     = flags[FLAG_BYP];
  assign erase_suspended = flags[FLAG_SUSP];
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              eng_busy,
  input logic              eng_erasing,
  input logic              chip_erase_go,
  input logic              sector_erase_go,
  input logic              program_go,
  input logic              autosel_go,
  input logic              unprotect_go,
  input logic              suspend_go,
  input logic              resume_go,
  input logic [ADDR_W-1:0] op_addr,
  input logic              autosel_mode,
  input logic              bypass_mode,
  input logic              erase_suspended
);
  logic [6:0] pulses;
  assign pulses = {chip_erase_go, sector_erase_go, program_go, autosel_go,
                   unprotect_go, suspend_go, resume_go};

  assert_onehot_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulses));

  assert_pulse_after_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulses) |-> $past(wr_valid));

  assert_chip_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_go |-> ($past(wr_data[7:0]) == 8'h10));

  assert_sector_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sector_erase_go |-> (op_addr == $past(wr_addr) && $past(wr_data[7:0]) == 8'h30));

  assert_asel_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    autosel_go |-> autosel_mode);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_go | sector_erase_go | program_go | autosel_go | unprotect_go)
      |-> !$past(eng_busy));

  assert_suspend_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_go |-> ($past(eng_erasing) && erase_suspended && !$past(erase_suspended)));

  assert_resume_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go |-> ($past(erase_suspended) && !erase_suspended));

  assert_no_bypass_in_pause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_mode) |-> !$past(erase_suspended));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fcd_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .eng_busy(eng_busy), .eng_erasing(eng_erasing),
  .chip_erase_go(chip_erase_go), .sector_erase_go(sector_erase_go),
  .program_go(program_go), .autosel_go(autosel_go),
  .unprotect_go(unprotect_go), .suspend_go(suspend_go),
  .resume_go(resume_go), .op_addr(op_addr), .autosel_mode(autosel_mode),
  .bypass_mode(bypass_mode), .erase_suspended(erase_suspended)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int AW = 20;
  localparam int DW = 32;

  // event codes used by the scoreboard
  localparam int C_CHIP = 1, C_SECT = 2, C_PROG = 3, C_ASEL = 4;
  localparam int C_UON = 5, C_UOFF = 6, C_SUSP = 7, C_RES = 8, C_MULTI = 15;

  typedef struct {
    int            code;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_mode = 1'b0, wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic eng_busy = 1'b0, eng_erasing = 1'b0;
  logic chip_erase_go, sector_erase_go, program_go, autosel_go;
  logic unprotect_go, unprotect_en, suspend_go, resume_go;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic autosel_mode, bypass_mode, erase_suspended;

  int checks = 0, errors = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .eng_busy(eng_busy),
    .eng_erasing(eng_erasing), .chip_erase_go(chip_erase_go),
    .sector_erase_go(sector_erase_go), .program_go(program_go),
    .autosel_go(autosel_go), .unprotect_go(unprotect_go),
    .unprotect_en(unprotect_en), .suspend_go(suspend_go),
    .resume_go(resume_go), .op_addr(op_addr), .op_data(op_data),
    .autosel_mode(autosel_mode), .bypass_mode(bypass_mode),
    .erase_suspended(erase_suspended)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ua();
    return word_mode ? 20'h00AAA : 20'h00555;
  endfunction
  function automatic logic [AW-1:0] ub();
    return word_mode ? 20'h00554 : 20'h002AA;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic push(input int code, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.code = code; e.a = a; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic unl();
    wr(ua(), 32'hAA);
    wr(ub(), 32'h55);
  endtask

  // monitor: pops an expected item for every pulse seen
  always @(negedge clk) begin
    if (rst_n) begin
      int code, n;
      n = chip_erase_go + sector_erase_go + program_go + autosel_go +
          unprotect_go + suspend_go + resume_go;
      code = 0;
      if (n > 1) code = C_MULTI;
      else if (chip_erase_go) code = C_CHIP;
      else if (sector_erase_go) code = C_SECT;
      else if (program_go) code = C_PROG;
      else if (autosel_go) code = C_ASEL;
      else if (unprotect_go) code = unprotect_en ? C_UON : C_UOFF;
      else if (suspend_go) code = C_SUSP;
      else if (resume_go) code = C_RES;
      if (code != 0) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8/R12 unexpected pulse", code, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(code == e.code, {e.tag, " event"}, code, e.code);
          chk(op_addr == e.a, {e.tag, " op_addr"}, int'(op_addr), int'(e.a));
          chk(op_data == e.d, {e.tag, " op_data"}, int'(op_data), int'(e.d));
        end
      end
    end
  end

  task automatic drain(input string tag);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, tag, q.size(), 0);
    q.delete();
  endtask

  bit done = 1'b0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({autosel_mode, bypass_mode, erase_suspended} == 3'b000, "reset flags",
        {autosel_mode, bypass_mode, erase_suspended}, 0);

    // R1 R2: 32-bit chip erase, upper address bits ignored
    word_mode = 1'b0;
    unl(); wr(20'hF0555, 32'h80); unl();
    push(C_CHIP, 20'h00555, 32'h10, "R2 chip erase dword");
    wr(20'h00555, 32'h10);
    drain("R2 chip erase done");

    // R1 R3: 16-bit sector erase
    word_mode = 1'b1;
    unl(); wr(ua(), 32'h80); unl();
    push(C_SECT, 20'h12345, 32'h30, "R3 sector erase word");
    wr(20'h12345, 32'h30);
    drain("R3 sector done");

    // R4: program in 32-bit mode
    word_mode = 1'b0;
    unl(); wr(ua(), 32'hA0);
    push(C_PROG, 20'h0ABCD, 32'hDEADBEEF, "R4 program");
    wr(20'h0ABCD, 32'hDEADBEEF);
    drain("R4 program done");

    // R1 R8: 16-bit addresses while in 32-bit mode abort
    wr(20'h00AAA, 32'hAA); wr(20'h002AA, 32'h55); wr(20'h00555, 32'hA0);
    wr(20'h01000, 32'h1234);
    drain("R1 wrong-mode unlock gives no pulse");
    // R8: bad data in the middle of an erase sequence
    unl(); wr(ua(), 32'h80); wr(ua(), 32'hAA); wr(ub(), 32'h56); wr(ua(), 32'h10);
    drain("R8 broken erase gives no pulse");

    // R5: identifier mode and reset
    unl();
    push(C_ASEL, ua(), 32'h90, "R5 autoselect");
    wr(ua(), 32'h90);
    chk(autosel_mode == 1'b1, "R5 autosel flag set", autosel_mode, 1);
    wr(20'h33333, 32'hF0);
    chk(autosel_mode == 1'b0, "R5 reset clears flag", autosel_mode, 0);
    unl();
    push(C_ASEL, ua(), 32'h90, "R5 autoselect again");
    wr(ua(), 32'h90);
    wr(20'h00100, 32'h77);
    chk(autosel_mode == 1'b0, "R8 abort clears autosel", autosel_mode, 0);
    drain("R5 done");

    // R6: protection override
    word_mode = 1'b1;
    unl(); wr(ua(), 32'h60);
    push(C_UON, 20'h00042, 32'h01, "R6 unprotect on");
    wr(20'h00042, 32'h01);
    unl(); wr(ua(), 32'h60);
    push(C_UOFF, 20'h00043, 32'h00, "R6 unprotect off");
    wr(20'h00043, 32'h00);
    unl(); wr(ua(), 32'h60); wr(20'h00044, 32'h05);
    drain("R6 done");

    // R7: fast-program mode
    unl(); wr(ua(), 32'h20);
    chk(bypass_mode == 1'b1, "R7 bypass set", bypass_mode, 1);
    wr(20'h00000, 32'hA0);
    push(C_PROG, 20'h05555, 32'hCAFE0001, "R7 bypass program");
    wr(20'h05555, 32'hCAFE0001);
    wr(20'h00000, 32'h90); wr(20'h00000, 32'h00);
    chk(bypass_mode == 1'b0, "R7 bypass exit", bypass_mode, 0);
    wr(20'h00000, 32'hA0); wr(20'h00010, 32'h12);
    drain("R7 short program rejected after exit");

    // R9: busy blocks sequences
    eng_busy = 1'b1;
    unl(); wr(ua(), 32'h80); unl(); wr(ua(), 32'h10);
    unl(); wr(ua(), 32'h90);
    chk(autosel_mode == 1'b0, "R9 busy blocks autoselect", autosel_mode, 0);
    drain("R9 busy gives no pulse");
    // R10: pause only while erasing
    wr(20'h0, 32'hB0);
    chk(erase_suspended == 1'b0, "R10 no pause when not erasing", erase_suspended, 0);
    eng_erasing = 1'b1;
    push(C_SUSP, 20'h00007, 32'hB0, "R10 suspend");
    wr(20'h00007, 32'hB0);
    chk(erase_suspended == 1'b1, "R10 suspended flag", erase_suspended, 1);
    eng_busy = 1'b0; eng_erasing = 1'b0;

    // R11: erase set-up and bypass entry rejected while paused
    unl(); wr(ua(), 32'h80); unl(); wr(ua(), 32'h10);
    unl(); wr(ua(), 32'h20);
    chk(bypass_mode == 1'b0, "R11 bypass entry rejected", bypass_mode, 0);
    drain("R11 no erase while paused");
    // normal program is still allowed while paused
    unl(); wr(ua(), 32'hA0);
    push(C_PROG, 20'h00200, 32'h0000BEEF, "R11 program while paused");
    wr(20'h00200, 32'h0000BEEF);
    push(C_RES, 20'h00009, 32'h30, "R10 resume");
    wr(20'h00009, 32'h30);
    chk(erase_suspended == 1'b0, "R10 resume clears flag", erase_suspended, 0);
    drain("R10 done");

    // R11: fast-program rejected while paused
    unl(); wr(ua(), 32'h20);
    eng_busy = 1'b1; eng_erasing = 1'b1;
    push(C_SUSP, 20'h0, 32'hB0, "R10 suspend in bypass");
    wr(20'h0, 32'hB0);
    eng_busy = 1'b0; eng_erasing = 1'b0;
    wr(20'h0, 32'hA0); wr(20'h00300, 32'h5A5A);
    drain("R11 bypass program rejected");
    push(C_RES, 20'h0, 32'h30, "R10 resume in bypass");
    wr(20'h0, 32'h30);
    wr(20'h0, 32'hA0);
    push(C_PROG, 20'h00301, 32'h6B6B, "R7 bypass program after resume");
    wr(20'h00301, 32'h6B6B);
    drain("R12 all pulses accounted");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule